// File: doc/BRIEF.md
# Scalable Watchdog Timer

A byte-register watchdog that counts down from a programmed value and raises a timeout when the count reaches zero. The count advances on a unit tick. The unit is either one input tick (seconds mode) or a fixed number of ticks taken through an internal prescaler (minutes mode). Software arms the timer by writing a nonzero count and disarms it by writing zero. Mouse and keyboard interrupt lines can each be allowed to restart the count, so input activity can keep the timer alive. Software can trigger a timeout directly, and so can a keyboard reset line when it is enabled.

Each timeout produces a one-cycle pulse and sets a sticky fired flag. While the flag is set, an interrupt routing code is presented on a side output, and a system-management request goes high when the code selects that route. A set flag blocks further timeouts until software clears it.

Top module: `wdt_scaled`

## Requirements
- R1: After reset all three registers read 0. `timeout_o`, `irq_code` and `smi_o` are 0. The address map is mode = 0, count = 1, control = 2. Address 3 always reads 0.
- R2: A write to address 1 loads the live count, which address 1 then reads back. Each unit tick lowers the count by exactly one. The count stops at zero and never wraps.
- R3: When a unit tick takes the count from 1 to 0, `timeout_o` is high for exactly one cycle, starting on the clock edge that takes the tick. The fired flag (control bit 4) becomes 1 on that same edge.
- R4: While the fired flag is 1, no event produces a timeout pulse. Writing 0 to control bit 4 clears the flag. Writing 1 to that bit leaves the flag unchanged.
- R5: Writing 0 to address 1 disarms the timer. After that, unit ticks produce no timeout.
- R6: With mode bit 3 set, one count unit equals UNIT_DIV input ticks. The prescaler restarts on every load or restart. With mode bit 3 clear, every tick is one unit.
- R7: Control bit 7 lets a `mouse_irq` cycle reload the count, and control bit 6 does the same for a `kbd_irq` cycle. The reload value is the last value written to address 1. An input whose enable bit is clear has no effect.
- R8: A restart event has no effect while the last value written to address 1 is zero.
- R9: Writing a control byte with bit 5 set forces a timeout, subject to R4. Bit 5 is not stored and always reads 0.
- R10: With mode bit 2 set, a cycle with `kbd_p20` high forces a timeout, subject to R4. With mode bit 2 clear, `kbd_p20` is ignored.
- R11: `irq_code` equals control bits 3:0 while the fired flag is 1, and 0 otherwise. `smi_o` is high only while the flag is 1 and that code equals 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle base time tick |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, combinational from addr |
| mouse_irq | input | 1 | Mouse interrupt activity |
| kbd_irq | input | 1 | Keyboard interrupt activity |
| kbd_p20 | input | 1 | Keyboard reset request line |
| timeout_o | output | 1 | One-cycle timeout pulse |
| irq_code | output | 4 | Routing code while fired |
| smi_o | output | 1 | System-management request while fired |

## Verification
The bench targets the boundaries of the count. The last tick of an interval must produce exactly one pulse on the right edge; a design that checks for zero one cycle late would pulse late or twice. In minutes mode, the interval must last exactly UNIT_DIV ticks per count; an off-by-one prescaler would expire a tick early or late. A timer that has fired must stay silent until software clears the flag; a design that ignores the flag would pulse again when a later count expires. The remaining checks cover the force bit reading back as 0, restarts that are disabled or have a zero reload value, and the keyboard reset line with its enable off; a design that got any of these wrong would show a wrong register value or an unexpected pulse.

// File: rtl/wdt_scaled.sv
module wdt_scaled #(
  parameter int UNIT_DIV = 60,
  parameter int DW       = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          mouse_irq,
  input  logic          kbd_irq,
  input  logic          kbd_p20,
  output logic          timeout_o,
  output logic [3:0]    irq_code,
  output logic          smi_o
);
  localparam int PW = (UNIT_DIV > 1) ? $clog2(UNIT_DIV) : 1;
  localparam logic [PW-1:0] PLAST = PW'(UNIT_DIV - 1);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW-1:0] mode_q, rld_q, cnt_q;
  logic [PW-1:0] presc_q;
  logic [3:0]    route_q;
  logic          mrst_en_q, krst_en_q, fired_q, tmo_q;

  wire wr_mode   = wr_en && addr == 2'd0;
  wire wr_tmo    = wr_en && addr == 2'd1;
  wire wr_ctl    = wr_en && addr == 2'd2;
  wire long_unit = mode_q[3];
  wire p20_en    = mode_q[2];

  wire unit      = tick && (!long_unit || presc_q == PLAST);
  wire restart   = ((mouse_irq && mrst_en_q) || (kbd_irq && krst_en_q)) && rld_q != '0;
  wire expire    = unit && cnt_q == ONE && !wr_tmo && !restart;
  wire force_now = (wr_ctl && wdata[5]) || (p20_en && kbd_p20);
  wire fire      = (expire || force_now) && !fired_q;
  wire clr_flag  = wr_ctl && !wdata[4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q    <= '0;
      rld_q     <= '0;
      cnt_q     <= '0;
      presc_q   <= '0;
      route_q   <= '0;
      mrst_en_q <= 1'b0;
      krst_en_q <= 1'b0;
      fired_q   <= 1'b0;
      tmo_q     <= 1'b0;
    end else begin
      if (wr_mode) mode_q <= wdata;
      if (wr_ctl) begin
        mrst_en_q <= wdata[7];
        krst_en_q <= wdata[6];
        route_q   <= wdata[3:0];
      end
      if (wr_tmo) begin
        rld_q <= wdata;
        cnt_q <= wdata;
      end else if (restart) begin
        cnt_q <= rld_q;
      end else if (unit && cnt_q != '0) begin
        cnt_q <= cnt_q - ONE;
      end
      if (wr_tmo || restart || !long_unit) presc_q <= '0;
      else if (tick) presc_q <= (presc_q == PLAST) ? '0 : presc_q + PW'(1);
      fired_q <= fire || (fired_q && !clr_flag);
      tmo_q   <= fire;
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = mode_q;
      2'd1:    rdata = cnt_q;
      2'd2:    rdata = DW'({mrst_en_q, krst_en_q, 1'b0, fired_q, route_q});
      default: rdata = '0;
    endcase
  end

  assign timeout_o = tmo_q;
  assign irq_code  = fired_q ? route_q : 4'd0;
  assign smi_o     = fired_q && route_q == 4'd2;
endmodule

// File: rtl/wdt_scaled_chk.sv
module wdt_scaled_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tmo,
  input logic          fired,
  input logic          load,
  input logic [DW-1:0] cnt,
  input logic [3:0]    code
);
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |=> !tmo);
  p_flag_with_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |-> fired);
  p_no_refire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tmo |-> !$past(fired));
  p_rise_on_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt > $past(cnt)) |-> $past(load));
  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt < $past(cnt) && !$past(load)) |-> ($past(cnt) - cnt == DW'(1)));
  p_code_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !fired |-> code == 4'd0);
endmodule

bind wdt_scaled wdt_scaled_chk #(.DW(DW)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .tmo   (timeout_o),
  .fired (fired_q),
  .load  (wr_tmo || restart),
  .cnt   (cnt_q),
  .code  (irq_code)
);

// File: tb/tb_wdt_scaled.sv
module tb_wdt_scaled;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0, rdata;
  logic mouse_irq = 1'b0, kbd_irq = 1'b0, kbd_p20 = 1'b0;
  logic timeout_o, smi_o;
  logic [3:0] irq_code;

  int checks = 0, errors = 0, cyc = 0;
  int expq[$];
  bit done = 1'b0;

  wdt_scaled dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .mouse_irq(mouse_irq), .kbd_irq(kbd_irq),
    .kbd_p20(kbd_p20), .timeout_o(timeout_o), .irq_code(irq_code), .smi_o(smi_o));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: every pulse must match the next expected cycle
  always @(negedge clk) begin
    if (rst_n && timeout_o) begin
      if (expq.size() == 0) chk("R3/R4 unexpected timeout pulse", cyc, -1);
      else chk("R3 timeout pulse cycle", cyc, expq.pop_front());
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input bit fire_exp);
    @(negedge clk);
    if (fire_exp) expq.push_back(cyc + 1);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tk(input bit fire_exp);
    @(negedge clk);
    if (fire_exp) expq.push_back(cyc + 1);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic pin(input int which, input bit fire_exp);
    @(negedge clk);
    if (fire_exp) expq.push_back(cyc + 1);
    if (which == 0) mouse_irq = 1'b1;
    else if (which == 1) kbd_irq = 1'b1;
    else kbd_p20 = 1'b1;
    @(negedge clk);
    mouse_irq = 1'b0; kbd_irq = 1'b0; kbd_p20 = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    #2 v = rdata;
  endtask

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung");
      report();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state and map
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk("R1 register reset value", v, 0);
    end
    chk("R1 timeout_o reset", timeout_o, 0);
    chk("R1 irq_code reset", irq_code, 0);
    chk("R1 smi_o reset", smi_o, 0);

    // R2/R3 basic countdown, route code 2
    wr(2'd2, 8'h02, 0);
    wr(2'd1, 8'd3, 0);
    rd(2'd1, v); chk("R2 load readback", v, 3);
    tk(0); rd(2'd1, v); chk("R2 decrement", v, 2);
    tk(0); rd(2'd1, v); chk("R2 decrement", v, 1);
    tk(1); rd(2'd1, v); chk("R2 floor at zero", v, 0);
    rd(2'd2, v); chk("R3 fired flag set", v, 8'h12);
    chk("R11 irq_code while fired", irq_code, 2);
    chk("R11 smi_o for code 2", smi_o, 1);
    tk(0); rd(2'd1, v); chk("R2 no wrap below zero", v, 0);

    // R4 fired blocks refire; writing 1 keeps flag
    wr(2'd1, 8'd1, 0);
    tk(0); rd(2'd1, v); chk("R4 count expired silently", v, 0);
    wr(2'd2, 8'h12, 0);
    rd(2'd2, v); chk("R4 write 1 keeps flag", v, 8'h12);
    wr(2'd2, 8'h02, 0);
    rd(2'd2, v); chk("R4 write 0 clears flag", v, 8'h02);
    chk("R11 irq_code zero when clear", irq_code, 0);

    // R5 zero disables
    wr(2'd1, 8'd2, 0);
    wr(2'd1, 8'd0, 0);
    tk(0); tk(0); tk(0);
    rd(2'd1, v); chk("R5 disarmed count", v, 0);

    // R6 minutes mode, UNIT_DIV = 60
    wr(2'd0, 8'h08, 0);
    rd(2'd0, v); chk("R6 mode readback", v, 8'h08);
    wr(2'd1, 8'd2, 0);
    for (int i = 0; i < 59; i++) tk(0);
    rd(2'd1, v); chk("R6 held before unit end", v, 2);
    tk(0); rd(2'd1, v); chk("R6 one unit elapsed", v, 1);
    for (int i = 0; i < 59; i++) tk(0);
    rd(2'd1, v); chk("R6 held before second unit", v, 1);
    tk(1); rd(2'd1, v); chk("R6 expired after two units", v, 0);
    wr(2'd2, 8'h02, 0);
    wr(2'd0, 8'h00, 0);

    // R7 restarts
    wr(2'd2, 8'hC2, 0);
    wr(2'd1, 8'd3, 0);
    tk(0); tk(0);
    pin(0, 0); rd(2'd1, v); chk("R7 mouse restart", v, 3);
    tk(0);
    pin(1, 0); rd(2'd1, v); chk("R7 keyboard restart", v, 3);
    wr(2'd2, 8'h42, 0);
    tk(0);
    pin(0, 0); rd(2'd1, v); chk("R7 mouse restart disabled", v, 2);
    // R8 zero reload ignores restart
    wr(2'd1, 8'd0, 0);
    pin(1, 0); rd(2'd1, v); chk("R8 restart with zero reload", v, 0);

    // R9 forced timeout, route 5
    wr(2'd2, 8'h25, 1);
    rd(2'd2, v); chk("R9 force bit reads 0, flag set", v, 8'h15);
    chk("R11 irq_code route 5", irq_code, 5);
    chk("R11 smi_o off for code 5", smi_o, 0);
    wr(2'd2, 8'h05, 0);

    // R10 keyboard reset line
    pin(2, 0);
    rd(2'd2, v); chk("R10 p20 ignored when disabled", v, 8'h05);
    wr(2'd0, 8'h04, 0);
    pin(2, 1);
    rd(2'd2, v); chk("R10 p20 forced timeout", v, 8'h15);
    wr(2'd2, 8'h05, 0);
    wr(2'd0, 8'h00, 0);

    repeat (4) @(negedge clk);
    chk("R3 all expected pulses seen", expq.size(), 0);
    done = 1'b1;
    report();
    $finish;
  end
endmodule